// File: doc/BRIEF.md
# Matrix Key Scanner with Acknowledge Mask and Auto-Repeat

This block scans a grid of push switches, one row at a time, on a scan tick supplied from outside. It pulls one row line low and reads the column lines, which read low where a closed switch joins them to the active row. Each row gets a settling tick after it is selected and is sampled only on the tick after that. A key changes its debounced state only after it has been seen in its new state on several samples in a row. The debounced vector is brought out directly, so a host can read it as a register.

A host that has dealt with a key writes a one to that key's bit in an acknowledge mask. The key then drops out of the reported pressed vector until it is released. This lets the host treat every press as a one-shot event. For long presses, the lowest-numbered held key is tracked. A repeat pulse fires after a long initial hold, and then at intervals that get shorter until they reach a floor.

Top module: `keyScanTop`

## Requirements
- R1: After reset, `rowDriveN` selects row 0 (bit 0 low, all other bits high), `heldVec` and `pressedVec` are zero and `repeatPulse` is low.
- R2: Exactly one row line is low at any time, and the selection changes only on a scan tick. Counting ticks from reset, tick 2n is a settling tick and tick 2n+1 samples the columns. After each sampling tick the selection moves to the next row, in ascending order, wrapping from the last row to row 0.
- R3: Key index k = row*COLS + col. A column that reads 0 while its row is selected means that key is closed.
- R4: A held bit sets after DEB_SCANS consecutive samples of that key that read closed (default 2), and clears after DEB_SCANS consecutive samples that read open. A sample that agrees with the current state restarts the count, so a key that alternates on every sample never changes state.
- R5: `pressedVec` is the held vector with every acknowledged key removed.
- R6: A cycle with `ackWrEn` high acknowledges every currently held key whose bit in `ackWrData` is 1. A one written for a key that is not held has no effect.
- R7: A key's acknowledge bit clears when its held bit clears, so the next press of that key is reported again.
- R8: The tracked key is the lowest-index held key. Tracking begins in the cycle after the held vector changes. Counting scan ticks from then on, the first `repeatPulse` comes on the HOLD_TICKS-th tick (default 32). Later pulses follow at gaps of REP_START ticks, then half of that, and so on, never below REP_MIN (defaults 16, 8, then 4 from there on).
- R9: Tracking restarts with a new initial hold whenever the lowest held index changes, and stops when no key is held. `repeatPulse` is one cycle wide, appears in the cycle after the counting tick, and `repeatKey` holds the tracked index while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanTick | input | 1 | One-cycle scan interval strobe |
| colSenseN | input | COLS | Column sense lines, low = closed switch on the active row |
| ackWrEn | input | 1 | Acknowledge write strobe |
| ackWrData | input | ROWS*COLS | Write-one acknowledge bits, one per key |
| rowDriveN | output | ROWS | Row select lines, active low, one at a time |
| heldVec | output | ROWS*COLS | Debounced held state per key |
| pressedVec | output | ROWS*COLS | Held keys not yet acknowledged |
| repeatPulse | output | 1 | Auto-repeat event strobe |
| repeatKey | output | $clog2(ROWS*COLS) | Index of the tracked key |

## Verification
A row pointer or settle phase that is off by one shows up at once on `rowDriveN`. It also moves which column samples land on which key, so a swept single key lights the wrong bit within one scan frame. A debounce counter that fails to restart, or keeps a stale count, lets an alternating key through or sets a held bit one sample early or late. An acknowledge bit that does not clear on release hides the next press on `pressedVec` as soon as that key debounces again. A repeat stage or tick count that is wrong moves a pulse away from the expected tick numbers (32, 48, 56, 60 and so on), and this is visible within a single long hold.

// File: rtl/keyScanPkg.sv
package keyScanPkg;
  // Row index field is wide enough for up to 16 rows.
  localparam int ROW_IDX_W = 4;

  typedef struct packed {
    logic                 tick;    // a scan tick occurs this cycle
    logic                 sample;  // this tick samples the selected row
    logic [ROW_IDX_W-1:0] row;     // currently selected row
  } scanStrobe_t;
endpackage

// File: rtl/keyScanCtrl.sv
module keyScanCtrl
  import keyScanPkg::*;
#(
  parameter int ROWS = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            scanTick,
  output logic [ROWS-1:0] rowDriveN,
  output scanStrobe_t     strobe
);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [ROW_W-1:0] rowIdx;
  logic             samplePhase;  // 0: settle tick next, 1: sample tick next

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowIdx      <= '0;
      samplePhase <= 1'b0;
    end else if (scanTick) begin
      samplePhase <= ~samplePhase;
      if (samplePhase) begin
        rowIdx <= (rowIdx == ROW_W'(ROWS - 1)) ? '0 : rowIdx + ROW_W'(1);
      end
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign rowDriveN[r] = (rowIdx != ROW_W'(r));
  end

  assign strobe.tick   = scanTick;
  assign strobe.sample = scanTick && samplePhase;
  assign strobe.row    = ROW_IDX_W'(rowIdx);
endmodule

// File: rtl/keyScanDatapath.sv
module keyScanDatapath
  import keyScanPkg::*;
#(
  parameter int ROWS       = 4,
  parameter int COLS       = 4,
  parameter int DEB_SCANS  = 2,
  parameter int HOLD_TICKS = 32,
  parameter int REP_START  = 16,
  parameter int REP_MIN    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  scanStrobe_t                   strobe,
  input  logic [COLS-1:0]               colSenseN,
  input  logic                          ackWrEn,
  input  logic [ROWS*COLS-1:0]          ackWrData,
  output logic [ROWS*COLS-1:0]          heldVec,
  output logic [ROWS*COLS-1:0]          pressedVec,
  output logic                          repeatPulse,
  output logic [$clog2(ROWS*COLS)-1:0]  repeatKey
);
  localparam int KEYS   = ROWS * COLS;
  localparam int KEY_W  = $clog2(KEYS);
  localparam int DCNT_W = $clog2(DEB_SCANS + 1);
  localparam int TCNT_W = $clog2(HOLD_TICKS + REP_START + 1);
  localparam int STG_W  = $clog2($clog2(REP_START + 1) + 2);

  // ---------------- debounce per key ----------------
  logic [KEYS-1:0]             debQ, debNext;
  logic [KEYS-1:0][DCNT_W-1:0] cntQ, cntNext;
  logic [KEYS-1:0]             ackQ, ackNext;

  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      localparam int K = r * COLS + c;
      logic hit, closed, differs, settled;
      assign hit     = strobe.sample && (strobe.row == ROW_IDX_W'(r));
      assign closed  = !colSenseN[c];
      assign differs = hit && (closed != debQ[K]);
      assign settled = differs && (cntQ[K] == DCNT_W'(DEB_SCANS - 1));
      assign debNext[K] = settled ? closed : debQ[K];
      assign cntNext[K] = !hit ? cntQ[K] :
                          (differs && !settled) ? cntQ[K] + DCNT_W'(1) : '0;
    end
  end

  assign ackNext = (ackQ | (ackWrEn ? ackWrData : '0)) & debNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      debQ <= '0;
      cntQ <= '0;
      ackQ <= '0;
    end else begin
      debQ <= debNext;
      cntQ <= cntNext;
      ackQ <= ackNext;
    end
  end

  assign heldVec    = debQ;
  assign pressedVec = debQ & ~ackQ;

  // ---------------- auto-repeat on lowest held key ----------------
  logic             anyHeld;
  logic [KEY_W-1:0] lowKey;

  always_comb begin
    anyHeld = 1'b0;
    lowKey  = '0;
    for (int i = KEYS - 1; i >= 0; i--) begin
      if (debQ[i]) begin
        anyHeld = 1'b1;
        lowKey  = KEY_W'(i);
      end
    end
  end

  logic              trackValid;
  logic [KEY_W-1:0]  trackKey;
  logic [TCNT_W-1:0] tickCnt, tickInc, interval;
  logic [STG_W-1:0]  stage;
  logic              canAdvance;

  assign tickInc    = tickCnt + TCNT_W'(1);
  assign interval   = (stage == '0) ? TCNT_W'(HOLD_TICKS)
                                    : TCNT_W'(REP_START >> (int'(stage) - 1));
  assign canAdvance = (stage == '0) ? (REP_START >= REP_MIN)
                                    : ((REP_START >> int'(stage)) >= REP_MIN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trackValid  <= 1'b0;
      trackKey    <= '0;
      tickCnt     <= '0;
      stage       <= '0;
      repeatPulse <= 1'b0;
    end else begin
      repeatPulse <= 1'b0;
      if (!anyHeld) begin
        trackValid <= 1'b0;
        tickCnt    <= '0;
        stage      <= '0;
      end else if (!trackValid || lowKey != trackKey) begin
        trackValid <= 1'b1;
        trackKey   <= lowKey;
        tickCnt    <= '0;
        stage      <= '0;
      end else if (strobe.tick) begin
        if (tickInc == interval) begin
          repeatPulse <= 1'b1;
          tickCnt     <= '0;
          if (canAdvance) stage <= stage + STG_W'(1);
        end else begin
          tickCnt <= tickInc;
        end
      end
    end
  end

  assign repeatKey = trackKey;
endmodule

// File: rtl/keyScanTop.sv
module keyScanTop
  import keyScanPkg::*;
#(
  parameter int ROWS       = 4,
  parameter int COLS       = 4,
  parameter int DEB_SCANS  = 2,
  parameter int HOLD_TICKS = 32,
  parameter int REP_START  = 16,
  parameter int REP_MIN    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          scanTick,
  input  logic [COLS-1:0]               colSenseN,
  input  logic                          ackWrEn,
  input  logic [ROWS*COLS-1:0]          ackWrData,
  output logic [ROWS-1:0]               rowDriveN,
  output logic [ROWS*COLS-1:0]          heldVec,
  output logic [ROWS*COLS-1:0]          pressedVec,
  output logic                          repeatPulse,
  output logic [$clog2(ROWS*COLS)-1:0]  repeatKey
);
  scanStrobe_t strobe;

  keyScanCtrl #(.ROWS(ROWS)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .scanTick  (scanTick),
    .rowDriveN (rowDriveN),
    .strobe    (strobe)
  );

  keyScanDatapath #(
    .ROWS(ROWS), .COLS(COLS), .DEB_SCANS(DEB_SCANS),
    .HOLD_TICKS(HOLD_TICKS), .REP_START(REP_START), .REP_MIN(REP_MIN)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .colSenseN   (colSenseN),
    .ackWrEn     (ackWrEn),
    .ackWrData   (ackWrData),
    .heldVec     (heldVec),
    .pressedVec  (pressedVec),
    .repeatPulse (repeatPulse),
    .repeatKey   (repeatKey)
  );
endmodule

// File: rtl/keyScanChecker.sv
module keyScanChecker #(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          scanTick,
  input logic [COLS-1:0]               colSenseN,
  input logic                          ackWrEn,
  input logic [ROWS*COLS-1:0]          ackWrData,
  input logic [ROWS-1:0]               rowDriveN,
  input logic [ROWS*COLS-1:0]          heldVec,
  input logic [ROWS*COLS-1:0]          pressedVec,
  input logic                          repeatPulse,
  input logic [$clog2(ROWS*COLS)-1:0]  repeatKey
);
  localparam int KEYS = ROWS * COLS;

  a_r2_one_row: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~rowDriveN) == 1);

  a_r2_row_moves_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !scanTick |=> $stable(rowDriveN));

  a_r4_held_moves_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !scanTick |=> $stable(heldVec));

  a_r6_ack_hides: assert property (@(posedge clk) disable iff (!rstN)
    ackWrEn |=> ((pressedVec & $past(ackWrData)) == '0));

  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    repeatPulse |=> !repeatPulse);

  a_r8_pulse_on_held: assert property (@(posedge clk) disable iff (!rstN)
    repeatPulse |-> (|($past(heldVec) & (KEYS'(1) << repeatKey))));
endmodule

bind keyScanTop keyScanChecker #(.ROWS(ROWS), .COLS(COLS)) chk_i (.*);

// File: tb/keyScanTop_tb_top.sv
module keyScanTop_tb_top;
  localparam int ROWS = 4, COLS = 4, KEYS = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scanTick = 1'b0;
  logic [COLS-1:0] colSenseN;
  logic ackWrEn = 1'b0;
  logic [KEYS-1:0] ackWrData = '0;
  logic [ROWS-1:0] rowDriveN;
  logic [KEYS-1:0] heldVec, pressedVec;
  logic repeatPulse;
  logic [3:0] repeatKey;

  always #4 clk = ~clk;  // 125 MHz

  keyScanTop dut_i (.*);

  // switch matrix model: closed key pulls its column low when its row is low
  logic [KEYS-1:0] keyState = '0;
  always_comb begin
    colSenseN = '1;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (!rowDriveN[r] && keyState[r*COLS+c]) colSenseN[c] = 1'b0;
  end

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model, built from the requirements
  int tickNo = 0;
  bit [KEYS-1:0] mDeb = '0, mAck = '0;
  int mCnt[KEYS];
  bit mValid = 0;
  int mKey = 0, mTicks = 0, mStage = 0;
  int pulseTicks[$];

  function automatic int lowest(bit [KEYS-1:0] v);
    for (int i = 0; i < KEYS; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int gapFor(int s);
    int g;
    if (s == 0) return 32;
    g = 16 >> (s - 1);
    return (g < 4) ? 4 : g;
  endfunction

  task automatic doTick();
    int row, exPulse;
    exPulse = 0;
    @(negedge clk);
    row = (tickNo / 2) % ROWS;
    chk(rowDriveN == ~(4'b1 << row), "R2 row select", rowDriveN, ~(4'b1 << row));
    // repeat counting uses the state before this tick
    if (mDeb != 0 && mValid && lowest(mDeb) == mKey) begin
      mTicks++;
      if (mTicks == gapFor(mStage)) begin
        exPulse = 1; mTicks = 0; mStage++;
      end
    end
    if (tickNo % 2 == 1) begin
      for (int c = 0; c < COLS; c++) begin
        int k;
        k = row * COLS + c;
        if (keyState[k] != mDeb[k]) begin
          mCnt[k]++;
          if (mCnt[k] == 2) begin mDeb[k] = keyState[k]; mCnt[k] = 0; end
        end else mCnt[k] = 0;
      end
    end
    mAck &= mDeb;
    scanTick = 1'b1;
    @(negedge clk);
    scanTick = 1'b0;
    chk(heldVec == mDeb, "R4 held vector", heldVec, mDeb);
    chk(pressedVec == (mDeb & ~mAck), "R5 pressed vector", pressedVec, mDeb & ~mAck);
    chk(repeatPulse == exPulse[0], "R8 R9 repeat pulse", repeatPulse, exPulse);
    if (exPulse != 0) begin
      chk(repeatKey == mKey[3:0], "R9 repeat key", repeatKey, mKey);
      pulseTicks.push_back(tickNo);
    end
    // tracking update happens in the cycle after the held vector changes
    if (mDeb == 0) mValid = 0;
    else if (!mValid || lowest(mDeb) != mKey) begin
      mValid = 1; mKey = lowest(mDeb); mTicks = 0; mStage = 0;
    end
    tickNo++;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) doTick();
  endtask

  task automatic ackWrite(input logic [KEYS-1:0] m);
    @(negedge clk);
    ackWrEn = 1'b1; ackWrData = m;
    mAck = (mAck | m) & mDeb;
    @(negedge clk);
    ackWrEn = 1'b0; ackWrData = '0;
    chk(pressedVec == (mDeb & ~mAck), "R6 ack write", pressedVec, mDeb & ~mAck);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int debTick;
    for (int i = 0; i < KEYS; i++) mCnt[i] = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rowDriveN == 4'b1110, "R1 rows after reset", rowDriveN, 4'b1110);
    chk(heldVec == 0, "R1 held after reset", heldVec, 0);
    chk(pressedVec == 0, "R1 pressed after reset", pressedVec, 0);
    chk(repeatPulse == 0, "R1 pulse after reset", repeatPulse, 0);

    // R3 sweep every key alone
    for (int k = 0; k < KEYS; k++) begin
      keyState = KEYS'(1) << k;
      ticks(24);
      chk(heldVec == (KEYS'(1) << k), "R3 key index", heldVec, KEYS'(1) << k);
      keyState = '0;
      ticks(24);
      chk(heldVec == 0, "R4 release", heldVec, 0);
    end

    // R4 key alternating every sample never debounces
    for (int f = 0; f < 6; f++) begin
      keyState = (f % 2 == 0) ? 16'h0020 : 16'h0000;
      ticks(8);
    end
    chk(heldVec == 0, "R4 alternating key ignored", heldVec, 0);
    keyState = '0;
    ticks(16);

    // R6 ack for an unheld key has no effect
    ackWrite(16'h0200);
    keyState = 16'h0200;
    ticks(24);
    chk(pressedVec == 16'h0200, "R6 unheld ack ignored", pressedVec, 16'h0200);
    // R5 / R6 ack hides a held key
    ackWrite(16'h0200);
    chk(pressedVec == 0 && heldVec == 16'h0200, "R5 acked key hidden", pressedVec, 0);
    // R7 release clears ack, next press is reported
    keyState = '0;
    ticks(24);
    keyState = 16'h0200;
    ticks(24);
    chk(pressedVec == 16'h0200, "R7 ack cleared on release", pressedVec, 16'h0200);
    keyState = '0;
    ticks(24);

    // R8 repeat gaps on a long hold
    pulseTicks.delete();
    keyState = 16'h0008;
    debTick = -1;
    while (debTick < 0) begin
      doTick();
      if (heldVec[3]) debTick = tickNo - 1;
    end
    ticks(100);
    begin
      int exp;
      exp = debTick;
      for (int i = 0; i < 6; i++) begin
        exp += gapFor(i);
        chk(pulseTicks.size() > i && pulseTicks[i] == exp, "R8 repeat schedule",
            (pulseTicks.size() > i) ? pulseTicks[i] : -1, exp);
      end
    end

    // R9 lower key takes over tracking
    keyState = 16'h0408;
    ticks(20);
    keyState = 16'h0404;  // release 3, press 2
    ticks(60);
    keyState = '0;
    ticks(24);
    chk(heldVec == 0 && repeatPulse == 0, "R9 idle after release", heldVec, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule